// File: doc/BRIEF.md
# Interrupt Domain Register Decoder

This block sits between a simple request/response register bus and the per-source interrupt logic of one interrupt domain. It accepts aligned 32-bit accesses on a word-addressed offset space, classifies each offset into one of a fixed set of regions, and turns the access into a registered response plus one-cycle strobes for the downstream logic. Those strobes are a per-source configuration write, a per-source target write, a message-generation write, and four source-wide masks that set or clear pending and enable state.

Bitmap regions pack 32 sources per word. Reads of those words gather pending, enable or rectified input state supplied by the source logic. Single-number regions name one source in the write data. One of them takes the number with its four bytes reversed. The only state held here is the domain interrupt-enable bit. Every accepted write also pulses a rescan request, so the forwarder re-examines all sources after any register change.

Top module: `irq_reg_decoder`

## Requirements
- R1: A request whose offset bits [1:0] are not zero, or whose size is not 4 bytes, gets an error response with read data 0 and raises no strobe.
- R2: A request to an offset outside every region below gets an error response with read data 0 and raises no strobe.
- R3: Domain configuration is at offset 0x0000. A write updates only the enable bit, taken from data bit 8 and driven on `ie_o`. A read returns 0x8000_0000, plus bit 2 always set, plus the enable bit at bit 8.
- R4: Source configuration entries start at 0x0004 and target entries at 0x3004. Offset base+4*(k-1) addresses source k, for k from 1 to NUM_SRC-1. A read returns `cfg_rdata_i` or `tgt_rdata_i` while `rd_idx_o` equals k. A write pulses `cfg_we_o` or `tgt_we_o` with `wr_idx_o`=k and `wr_data_o` equal to the write data.
- R5: The bitmap regions each span ceil(NUM_SRC/32) words: set-pending at 0x1C00, clear-pending at 0x1D00, set-enable at 0x1E00 and clear-enable at 0x1F00. Bit b of a write to word w marks source w*32+b in the matching mask. Source 0 and numbers at or above NUM_SRC are never marked.
- R6: A bitmap read of word w returns, at bit b, the state of source w*32+b, or 0 for source 0 and for numbers out of range. Set-pending words return pending state, clear-pending words return rectified input, set-enable words return enable state, and clear-enable words return 0.
- R7: The single-number registers are set-pending at 0x1CDC and 0x2000, clear-pending at 0x1DDC, set-enable at 0x1EDC and clear-enable at 0x1FDC. All of them read as 0. A write marks the single source whose number equals the data, and marks nothing if that number is 0 or at least NUM_SRC.
- R8: The byte-reversed set-pending-number register is at 0x2004. Its data bytes are reversed before use as the number, so 0x0500_0000 names source 5.
- R9: Offset 0x3000 is the message-generation register. A read returns `gen_rdata_i`. A write pulses `gen_we_o` with the data on `wr_data_o`.
- R10: Every request gets `rsp_valid_o` in the following cycle. All strobes and masks last exactly that one cycle. `rescan_o` pulses in that cycle for each write without error, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset in the register space |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response, one cycle after the request |
| rsp_err_o | output | 1 | Response is an error |
| rsp_rdata_o | output | 32 | Read data, 0 for writes and errors |
| ie_o | output | 1 | Domain interrupt enable |
| rd_idx_o | output | IDX_W | Source index of the current configuration or target access |
| cfg_rdata_i | input | 32 | Configuration of source `rd_idx_o` |
| tgt_rdata_i | input | 32 | Target of source `rd_idx_o` |
| gen_rdata_i | input | 32 | Message-generation register contents |
| src_pend_i | input | NUM_SRC | Pending state per source |
| src_en_i | input | NUM_SRC | Enable state per source |
| src_in_i | input | NUM_SRC | Rectified input per source |
| cfg_we_o | output | 1 | Configuration write strobe |
| tgt_we_o | output | 1 | Target write strobe |
| gen_we_o | output | 1 | Message-generation write strobe |
| wr_idx_o | output | IDX_W | Source index for configuration or target writes |
| wr_data_o | output | 32 | Write data for the strobes |
| ip_set_o | output | NUM_SRC | Sources to mark pending |
| ip_clr_o | output | NUM_SRC | Sources to clear pending |
| ie_set_o | output | NUM_SRC | Sources to enable |
| ie_clr_o | output | NUM_SRC | Sources to disable |
| rescan_o | output | 1 | Rescan request to the forwarder |

## Verification
The bench drives all-ones words to both bitmap words. This shows that source 0 and the unused bits of the partial last word are dropped. It also drives sparse words, which confirm that bit b maps to source w*32+b. For the single-number registers it uses numbers 0, 5, the last valid source and one past it, and it writes the byte-reversed register both with and without reversal. This separates a swap done on the data from a swap left out. For reads it changes the pending, enable and input vectors between phases, so a bitmap region that reads the wrong vector shows as a mismatch. It also accesses the first and last configuration and target entries and the entry just past them, misaligned addresses, wrong sizes and gaps in the map, which exposes off-by-one errors in the region bounds.

// File: rtl/irq_dec_pkg.sv
package irq_dec_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_DCFG, RG_SCFG, RG_TGT, RG_GMSI,
    RG_SETIP, RG_CLRIP, RG_SETIE, RG_CLRIE,
    RG_SETIPN, RG_CLRIPN, RG_SETIEN, RG_CLRIEN,
    RG_IPN_LE, RG_IPN_BE
  } region_e;

  localparam int unsigned OFS_DCFG   = 'h0000;
  localparam int unsigned OFS_SCFG   = 'h0004;
  localparam int unsigned OFS_SETIP  = 'h1C00;
  localparam int unsigned OFS_SETIPN = 'h1CDC;
  localparam int unsigned OFS_CLRIP  = 'h1D00;
  localparam int unsigned OFS_CLRIPN = 'h1DDC;
  localparam int unsigned OFS_SETIE  = 'h1E00;
  localparam int unsigned OFS_SETIEN = 'h1EDC;
  localparam int unsigned OFS_CLRIE  = 'h1F00;
  localparam int unsigned OFS_CLRIEN = 'h1FDC;
  localparam int unsigned OFS_IPN_LE = 'h2000;
  localparam int unsigned OFS_IPN_BE = 'h2004;
  localparam int unsigned OFS_GMSI   = 'h3000;
  localparam int unsigned OFS_TGT    = 'h3004;

  localparam logic [31:0] DCFG_FIXED = 32'h8000_0000;
  localparam int unsigned DCFG_IE_BIT = 8;
  localparam int unsigned DCFG_DM_BIT = 2;

  function automatic logic [31:0] byte_rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

endpackage

// File: rtl/irq_dec_addr.sv
module irq_dec_addr
  import irq_dec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 48,
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned WIDX_W  = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  ent_idx_o,
  output logic [WIDX_W-1:0] word_idx_o
);
  localparam int unsigned WORDS    = (NUM_SRC + 31) / 32;
  localparam int unsigned ENT_SPAN = 4 * (NUM_SRC - 1);
  localparam int unsigned MAP_SPAN = 4 * WORDS;

  logic [31:0] ofs;
  logic [31:0] ent_off;
  logic [31:0] bm_off;

  assign ofs = 32'(addr_i);

  function automatic logic in_rng(input logic [31:0] a, input int unsigned base,
                                  input int unsigned span);
    return (a >= base) && (a < base + span);
  endfunction

  always_comb begin
    region_o = RG_NONE;
    ent_off  = '0;
    bm_off   = '0;
    if (ofs == OFS_DCFG) begin
      region_o = RG_DCFG;
    end else if (in_rng(ofs, OFS_SCFG, ENT_SPAN)) begin
      region_o = RG_SCFG;
      ent_off  = ofs - OFS_SCFG;
    end else if (in_rng(ofs, OFS_TGT, ENT_SPAN)) begin
      region_o = RG_TGT;
      ent_off  = ofs - OFS_TGT;
    end else if (in_rng(ofs, OFS_SETIP, MAP_SPAN)) begin
      region_o = RG_SETIP;
      bm_off   = ofs - OFS_SETIP;
    end else if (in_rng(ofs, OFS_CLRIP, MAP_SPAN)) begin
      region_o = RG_CLRIP;
      bm_off   = ofs - OFS_CLRIP;
    end else if (in_rng(ofs, OFS_SETIE, MAP_SPAN)) begin
      region_o = RG_SETIE;
      bm_off   = ofs - OFS_SETIE;
    end else if (in_rng(ofs, OFS_CLRIE, MAP_SPAN)) begin
      region_o = RG_CLRIE;
      bm_off   = ofs - OFS_CLRIE;
    end else if (ofs == OFS_SETIPN) begin
      region_o = RG_SETIPN;
    end else if (ofs == OFS_CLRIPN) begin
      region_o = RG_CLRIPN;
    end else if (ofs == OFS_SETIEN) begin
      region_o = RG_SETIEN;
    end else if (ofs == OFS_CLRIEN) begin
      region_o = RG_CLRIEN;
    end else if (ofs == OFS_IPN_LE) begin
      region_o = RG_IPN_LE;
    end else if (ofs == OFS_IPN_BE) begin
      region_o = RG_IPN_BE;
    end else if (ofs == OFS_GMSI) begin
      region_o = RG_GMSI;
    end
  end

  // entries start at source 1
  assign ent_idx_o  = IDX_W'((ent_off >> 2) + 32'd1);
  assign word_idx_o = WIDX_W'(bm_off >> 2);

endmodule

// File: rtl/irq_dec_bitmap.sv
module irq_dec_bitmap #(
  parameter int unsigned NUM_SRC = 48,
  parameter int unsigned WIDX_W  = 1
) (
  input  logic [WIDX_W-1:0]  word_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] in_i,
  output logic [31:0]        pend_word_o,
  output logic [31:0]        en_word_o,
  output logic [31:0]        in_word_o,
  output logic [NUM_SRC-1:0] wmask_o
);
  localparam int unsigned WORDS = (NUM_SRC + 31) / 32;
  localparam int unsigned PAD_W = WORDS * 32;

  logic [PAD_W-1:0] valid_pad;
  logic [PAD_W-1:0] pend_pad, en_pad, in_pad;

  for (genvar i = 0; i < PAD_W; i++) begin : g_valid
    if (i == 0 || i >= NUM_SRC) begin : g_off
      assign valid_pad[i] = 1'b0;
    end else begin : g_on
      assign valid_pad[i] = 1'b1;
    end
  end

  assign pend_pad = PAD_W'(pend_i) & valid_pad;
  assign en_pad   = PAD_W'(en_i)   & valid_pad;
  assign in_pad   = PAD_W'(in_i)   & valid_pad;

  assign pend_word_o = pend_pad[{word_i, 5'b0} +: 32];
  assign en_word_o   = en_pad[{word_i, 5'b0} +: 32];
  assign in_word_o   = in_pad[{word_i, 5'b0} +: 32];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_wmask
    if (i == 0) begin : g_zero
      assign wmask_o[i] = 1'b0;
    end else begin : g_bit
      assign wmask_o[i] = (word_i == WIDX_W'(i / 32)) && wdata_i[i % 32];
    end
  end

endmodule

// File: rtl/irq_dec_num.sv
module irq_dec_num
  import irq_dec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 48
) (
  input  logic [31:0]        data_i,
  input  logic               swap_i,
  output logic [NUM_SRC-1:0] onehot_o
);
  logic [31:0] num;

  assign num = swap_i ? byte_rev(data_i) : data_i;

  // numbers 0 and >= NUM_SRC match no bit
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_oh
    if (i == 0) begin : g_zero
      assign onehot_o[i] = 1'b0;
    end else begin : g_cmp
      assign onehot_o[i] = (num == 32'(i));
    end
  end

endmodule

// File: rtl/irq_reg_decoder.sv
module irq_reg_decoder
  import irq_dec_pkg::*;
#(
  parameter int unsigned NUM_SRC = 48,
  parameter int unsigned ADDR_W  = 14,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [2:0]         req_size_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [31:0]        rsp_rdata_o,
  output logic               ie_o,
  output logic [IDX_W-1:0]   rd_idx_o,
  input  logic [31:0]        cfg_rdata_i,
  input  logic [31:0]        tgt_rdata_i,
  input  logic [31:0]        gen_rdata_i,
  input  logic [NUM_SRC-1:0] src_pend_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] src_in_i,
  output logic               cfg_we_o,
  output logic               tgt_we_o,
  output logic               gen_we_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [31:0]        wr_data_o,
  output logic [NUM_SRC-1:0] ip_set_o,
  output logic [NUM_SRC-1:0] ip_clr_o,
  output logic [NUM_SRC-1:0] ie_set_o,
  output logic [NUM_SRC-1:0] ie_clr_o,
  output logic               rescan_o
);
  localparam int unsigned WORDS  = (NUM_SRC + 31) / 32;
  localparam int unsigned WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  region_e            region;
  logic [IDX_W-1:0]   ent_idx;
  logic [WIDX_W-1:0]  word_idx;
  logic [31:0]        pend_word, en_word, in_word;
  logic [NUM_SRC-1:0] word_mask, num_mask;

  irq_dec_addr #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIDX_W(WIDX_W)
  ) u_addr (
    .addr_i    (req_addr_i),
    .region_o  (region),
    .ent_idx_o (ent_idx),
    .word_idx_o(word_idx)
  );

  irq_dec_bitmap #(.NUM_SRC(NUM_SRC), .WIDX_W(WIDX_W)) u_bitmap (
    .word_i     (word_idx),
    .wdata_i    (req_wdata_i),
    .pend_i     (src_pend_i),
    .en_i       (src_en_i),
    .in_i       (src_in_i),
    .pend_word_o(pend_word),
    .en_word_o  (en_word),
    .in_word_o  (in_word),
    .wmask_o    (word_mask)
  );

  irq_dec_num #(.NUM_SRC(NUM_SRC)) u_num (
    .data_i  (req_wdata_i),
    .swap_i  (region == RG_IPN_BE),
    .onehot_o(num_mask)
  );

  logic ok, wr_ok, rd_ok;
  logic dcfg_wr, num_wr;
  logic [31:0] rd_mux;
  logic [NUM_SRC-1:0] ip_set_d, ip_clr_d, ie_set_d, ie_clr_d;

  assign ok = req_valid_i && (req_addr_i[1:0] == 2'b00) && (req_size_i == 3'd4)
              && (region != RG_NONE);
  assign wr_ok   = ok && req_write_i;
  assign rd_ok   = ok && !req_write_i;
  assign dcfg_wr = wr_ok && (region == RG_DCFG);
  assign num_wr  = wr_ok && (region inside {RG_SETIPN, RG_CLRIPN, RG_SETIEN,
                                            RG_CLRIEN, RG_IPN_LE, RG_IPN_BE});
  assign rd_idx_o = ent_idx;

  logic ie_q;

  always_comb begin
    case (region)
      RG_DCFG:  rd_mux = DCFG_FIXED | (32'(ie_q) << DCFG_IE_BIT) | (32'd1 << DCFG_DM_BIT);
      RG_SCFG:  rd_mux = cfg_rdata_i;
      RG_TGT:   rd_mux = tgt_rdata_i;
      RG_GMSI:  rd_mux = gen_rdata_i;
      RG_SETIP: rd_mux = pend_word;
      RG_CLRIP: rd_mux = in_word;   // clear-pending words expose rectified inputs
      RG_SETIE: rd_mux = en_word;
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    ip_set_d = '0;
    ip_clr_d = '0;
    ie_set_d = '0;
    ie_clr_d = '0;
    if (wr_ok) begin
      case (region)
        RG_SETIP:                      ip_set_d = word_mask;
        RG_CLRIP:                      ip_clr_d = word_mask;
        RG_SETIE:                      ie_set_d = word_mask;
        RG_CLRIE:                      ie_clr_d = word_mask;
        RG_SETIPN, RG_IPN_LE, RG_IPN_BE: ip_set_d = num_mask;
        RG_CLRIPN:                     ip_clr_d = num_mask;
        RG_SETIEN:                     ie_set_d = num_mask;
        RG_CLRIEN:                     ie_clr_d = num_mask;
        default: ;
      endcase
    end
  end

  logic               rsp_valid_q, rsp_err_q, rescan_q;
  logic [31:0]        rsp_rdata_q, wr_data_q;
  logic               cfg_we_q, tgt_we_q, gen_we_q;
  logic [IDX_W-1:0]   wr_idx_q;
  logic [NUM_SRC-1:0] ip_set_q, ip_clr_q, ie_set_q, ie_clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      ie_q        <= 1'b0;
      cfg_we_q    <= 1'b0;
      tgt_we_q    <= 1'b0;
      gen_we_q    <= 1'b0;
      wr_idx_q    <= '0;
      wr_data_q   <= '0;
      ip_set_q    <= '0;
      ip_clr_q    <= '0;
      ie_set_q    <= '0;
      ie_clr_q    <= '0;
      rescan_q    <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= req_valid_i && !ok;
      rsp_rdata_q <= rd_ok ? rd_mux : '0;
      if (dcfg_wr) ie_q <= req_wdata_i[DCFG_IE_BIT];
      cfg_we_q    <= wr_ok && (region == RG_SCFG);
      tgt_we_q    <= wr_ok && (region == RG_TGT);
      gen_we_q    <= wr_ok && (region == RG_GMSI);
      if (wr_ok) begin
        wr_idx_q  <= ent_idx;
        wr_data_q <= req_wdata_i;
      end
      ip_set_q    <= ip_set_d;
      ip_clr_q    <= ip_clr_d;
      ie_set_q    <= ie_set_d;
      ie_clr_q    <= ie_clr_d;
      rescan_q    <= wr_ok;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign ie_o        = ie_q;
  assign cfg_we_o    = cfg_we_q;
  assign tgt_we_o    = tgt_we_q;
  assign gen_we_o    = gen_we_q;
  assign wr_idx_o    = wr_idx_q;
  assign wr_data_o   = wr_data_q;
  assign ip_set_o    = ip_set_q;
  assign ip_clr_o    = ip_clr_q;
  assign ie_set_o    = ie_set_q;
  assign ie_clr_o    = ie_clr_q;
  assign rescan_o    = rescan_q;

  // R1, R2: an error response carries no side effect
  a_r1_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> !rescan_o && !cfg_we_o && !tgt_we_o && !gen_we_o &&
                  ip_set_o == '0 && ip_clr_o == '0 && ie_set_o == '0 && ie_clr_o == '0);

  a_r2_err_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_rdata_o == '0);

  // R3: enable bit moves only after a domain configuration write
  a_r3_ie_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dcfg_wr) |-> $stable(ie_o));

  // R5: set and clear masks never overlap
  a_r5_masks_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ip_set_o & ip_clr_o) == '0 && (ie_set_o & ie_clr_o) == '0);

  // R7: a single-number write marks at most one source
  a_r7_num_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(num_wr) |-> $countones(ip_set_o | ip_clr_o | ie_set_o | ie_clr_o) <= 1);

  // R10: responses follow requests; rescan only on accepted writes
  a_r10_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i));

  a_r10_rescan_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rescan_o |-> rsp_valid_o && !rsp_err_o && $past(req_write_i));

  a_r10_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_o || tgt_we_o || gen_we_o) |-> rescan_o);

endmodule

// File: tb/irq_reg_decoder_tb_top.sv
`timescale 1ns/1ps
module irq_reg_decoder_tb_top;
  localparam int unsigned N      = 48;
  localparam int unsigned ADDR_W = 14;
  localparam int unsigned IDX_W  = $clog2(N);
  localparam int unsigned WORDS  = (N + 31) / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        req_size = 3'd4;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid, rsp_err, ie, cfg_we, tgt_we, gen_we, rescan;
  logic [31:0]       rsp_rdata, wr_data, cfg_rdata, tgt_rdata;
  logic [31:0]       gen_rdata = 32'h0123_4567;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [N-1:0]      src_pend = '0, src_en = '0, src_in = '0;
  logic [N-1:0]      ip_set, ip_clr, ie_set, ie_clr;

  assign cfg_rdata = 32'hC0F0_0000 | 32'(rd_idx);
  assign tgt_rdata = 32'h7A00_0000 | 32'(rd_idx);

  irq_reg_decoder #(.NUM_SRC(N), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .ie_o(ie), .rd_idx_o(rd_idx),
    .cfg_rdata_i(cfg_rdata), .tgt_rdata_i(tgt_rdata), .gen_rdata_i(gen_rdata),
    .src_pend_i(src_pend), .src_en_i(src_en), .src_in_i(src_in),
    .cfg_we_o(cfg_we), .tgt_we_o(tgt_we), .gen_we_o(gen_we),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .ip_set_o(ip_set), .ip_clr_o(ip_clr), .ie_set_o(ie_set), .ie_clr_o(ie_clr),
    .rescan_o(rescan)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R10";

  // reference model state and expectations
  bit          ie_m = 0;
  bit          e_valid, e_err, e_ie, e_cfg, e_tgt, e_gen, e_rescan;
  logic [31:0] e_rdata, e_wdata;
  int unsigned e_idx;
  logic [N-1:0] e_ips, e_ipc, e_ies, e_iec;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R10", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk(cur_tag, "rsp_err", 64'(rsp_err), 64'(e_err));
    chk(cur_tag, "rsp_rdata", 64'(rsp_rdata), 64'(e_rdata));
    chk("R3", "ie", 64'(ie), 64'(e_ie));
    chk("R4", "cfg_we", 64'(cfg_we), 64'(e_cfg));
    chk("R4", "tgt_we", 64'(tgt_we), 64'(e_tgt));
    chk("R9", "gen_we", 64'(gen_we), 64'(e_gen));
    if (e_cfg || e_tgt) chk("R4", "wr_idx", 64'(wr_idx), 64'(e_idx));
    if (e_cfg || e_tgt || e_gen) chk(cur_tag, "wr_data", 64'(wr_data), 64'(e_wdata));
    chk(cur_tag, "ip_set", 64'(ip_set), 64'(e_ips));
    chk(cur_tag, "ip_clr", 64'(ip_clr), 64'(e_ipc));
    chk(cur_tag, "ie_set", 64'(ie_set), 64'(e_ies));
    chk(cur_tag, "ie_clr", 64'(ie_clr), 64'(e_iec));
    chk("R10", "rescan", 64'(rescan), 64'(e_rescan));
  endtask

  function automatic bit in_span(int unsigned a, int unsigned base, int unsigned span);
    return a >= base && a < base + span;
  endfunction

  task automatic model(input bit v, input bit w, input int unsigned a, input int unsigned s,
                       input logic [31:0] d);
    int unsigned wi, n;
    int kind;  // 0 setip 1 clrip 2 setie 3 clrie
    logic [N-1:0] m;
    logic [31:0] rv;
    e_valid = v; e_err = 0; e_rdata = 0; e_cfg = 0; e_tgt = 0; e_gen = 0;
    e_rescan = 0; e_idx = 0; e_wdata = d;
    e_ips = '0; e_ipc = '0; e_ies = '0; e_iec = '0;
    e_ie = ie_m;
    if (!v) return;
    if (a % 4 != 0 || s != 4) begin e_err = 1; return; end
    kind = -1; m = '0; rv = 0;
    if (a == 0) begin
      if (w) begin ie_m = d[8]; e_ie = ie_m; end
      else e_rdata = 32'h8000_0004 | (32'(ie_m) << 8);
    end else if (in_span(a, 'h4, 4 * (N - 1))) begin
      e_idx = (a - 'h4) / 4 + 1;
      if (w) e_cfg = 1; else e_rdata = 32'hC0F0_0000 | e_idx;
    end else if (in_span(a, 'h3004, 4 * (N - 1))) begin
      e_idx = (a - 'h3004) / 4 + 1;
      if (w) e_tgt = 1; else e_rdata = 32'h7A00_0000 | e_idx;
    end else if (a == 'h3000) begin
      if (w) e_gen = 1; else e_rdata = gen_rdata;
    end else if (in_span(a, 'h1C00, 4 * WORDS)) begin kind = 0; wi = (a - 'h1C00) / 4;
    end else if (in_span(a, 'h1D00, 4 * WORDS)) begin kind = 1; wi = (a - 'h1D00) / 4;
    end else if (in_span(a, 'h1E00, 4 * WORDS)) begin kind = 2; wi = (a - 'h1E00) / 4;
    end else if (in_span(a, 'h1F00, 4 * WORDS)) begin kind = 3; wi = (a - 'h1F00) / 4;
    end else if (a == 'h1CDC || a == 'h2000 || a == 'h2004 || a == 'h1DDC ||
                 a == 'h1EDC || a == 'h1FDC) begin
      n = (a == 'h2004) ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
      if (w && n >= 1 && n < N) m[n] = 1'b1;
      kind = (a == 'h1DDC) ? 1 : (a == 'h1EDC) ? 2 : (a == 'h1FDC) ? 3 : 0;
      wi = 'hFFFF;  // marks single-number form
    end else begin
      e_err = 1; return;
    end
    if (kind >= 0 && wi != 'hFFFF) begin
      for (int b = 0; b < 32; b++) begin
        int unsigned id;
        id = wi * 32 + b;
        if (id >= 1 && id < N) begin
          if (w) m[id] = d[b];
          else case (kind)
            0: rv[b] = src_pend[id];
            1: rv[b] = src_in[id];
            2: rv[b] = src_en[id];
            default: rv[b] = 1'b0;
          endcase
        end
      end
      if (!w) e_rdata = rv;
    end
    if (w) begin
      e_rescan = 1;
      case (kind)
        0: e_ips = m;
        1: e_ipc = m;
        2: e_ies = m;
        3: e_iec = m;
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit v, input bit w, input int unsigned a, input int unsigned s,
                      input logic [31:0] d);
    @(negedge clk);
    if (!done) compare_all();
    req_valid = v; req_write = w; req_addr = ADDR_W'(a); req_size = 3'(s); req_wdata = d;
    model(v, w, a, s, d);
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d); step(1, 1, a, 4, d); endtask
  task automatic rd(input int unsigned a); step(1, 0, a, 4, 0); endtask
  task automatic idle(); step(0, 0, 0, 4, 0); endtask

  initial begin
    model(0, 0, 0, 4, 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    cur_tag = "R10"; idle(); idle();

    cur_tag = "R3";
    rd('h0); wr('h0, 32'hFFFF_FFFF); rd('h0); wr('h0, 32'h0000_00FF); rd('h0);
    wr('h0, 32'h0000_0100); idle();

    cur_tag = "R4";
    rd('h4); rd('h4 + 4 * (N - 2)); wr('h4, 32'h0000_0007); wr('h4 + 4 * 4, 32'hA5A5_0003);
    rd('h3004); rd('h3004 + 4 * (N - 2)); wr('h3004 + 4 * (N - 2), 32'h1234_5678); idle();

    cur_tag = "R2";
    rd('h4 + 4 * (N - 1)); wr('h3004 + 4 * (N - 1), 32'h1); rd('h1000); wr('h1C00 + 4 * WORDS, 32'hF);
    rd('h1CE0); wr('h2008, 5); idle();

    cur_tag = "R1";
    wr('h1C01, 32'hF); step(1, 0, 'h0002, 4, 0); step(1, 1, 'h1C00, 2, 32'hF);
    step(1, 0, 'h4, 1, 0); step(1, 1, 'h0, 8, 32'h100); idle();

    cur_tag = "R5";
    wr('h1C00, 32'hFFFF_FFFF); wr('h1C04, 32'hFFFF_FFFF); wr('h1D00, 32'h8000_0021);
    wr('h1D04, 32'h0001_8001); wr('h1E00, 32'h0000_0003); wr('h1F04, 32'h0000_8000);
    wr('h1F00, 32'h0); idle();

    cur_tag = "R6";
    src_pend = 48'hFFFF_FFFF_FFFF; src_en = 48'h1234_5678_9ABD; src_in = 48'h8001_0000_0003;
    rd('h1C00); rd('h1C04); rd('h1D00); rd('h1D04); rd('h1E00); rd('h1E04);
    rd('h1F00); rd('h1F04);
    src_pend = 48'h0F0F_0000_0002; src_in = 48'h0000_FFFF_FFFE;
    rd('h1C04); rd('h1D00); rd('h1C00); idle();

    cur_tag = "R7";
    wr('h1CDC, 5); wr('h1CDC, 0); wr('h1CDC, N); wr('h1CDC, N - 1); wr('h1DDC, 33);
    wr('h1EDC, 1); wr('h1FDC, 47); wr('h2000, 12); wr('h1FDC, 32'h1_0001);
    rd('h1CDC); rd('h1DDC); rd('h1EDC); rd('h1FDC); rd('h2000); rd('h2004); idle();

    cur_tag = "R8";
    wr('h2004, 32'h0500_0000); wr('h2004, 32'h2F00_0000); wr('h2004, 32'h0000_0005);
    wr('h2004, 32'h0100_0000); wr('h2004, 32'h3000_0000); idle();

    cur_tag = "R9";
    rd('h3000); wr('h3000, 32'hDEAD_BEEF); rd('h3000); idle();

    cur_tag = "R10";
    wr('h4, 1); wr('h1C00, 2); rd('h0); wr('h0, 0); idle(); idle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule